// File: doc/BRIEF.md
# Sixteen-bit down-counting timer with reload, capture and masked compare

This block is a 16-bit timer that counts down from a programmable top value. Each time it passes zero it reports a wrap. A prescaler divides the clock by 1, 2, 4 or 8 to set the count rate. Two capture inputs each go through a synchroniser and an edge detector, and a detected edge copies the live count into a capture register. An edge on the second input can also restart the count from the top value, so that successive captures give the time from one event to the next.

A masked comparison between the count and a compare value drives a PWM output. A one-cycle wrap pulse drives an overflow output. Each of these outputs has its own enable and polarity bits. Four sticky event flags combine with per-flag enables to form one interrupt request.

Software reaches the block through a byte-wide register port. A write happens on any clock edge where `wr_en` is high. Reads are combinational from `addr`. The port has no stall, and every access completes in one cycle.

Top module: `reload_capture_timer`

## Requirements
- R1: After reset the following hold: count (addresses 0xC low byte, 0xD high byte) reads 0; flags (address 0x3) read 0; `pwm_out`, `ovf_out` and `irq` are low; the reload register (0x4 low, 0x5 high) reads 0xFFFF; the mask register (0xA low, 0xB high) reads 0xFFFF.
- R2: While the run bit (address 0x0, bit 0) is 0, the count is held at 0 and no wrap or compare event occurs.
- R3: The prescaler select field (address 0x0, bits 4:3) value s sets a ratio of 2^s. When run is set at clock edge E, the first count update happens at edge E+ratio, and later updates follow every ratio edges.
- R4: At each update the count decrements by one. If the count is 0 at an update, it instead loads the top value and the overflow flag (flags bit 0) is set. The top value is the reload register when the reload-mode bit (address 0x0, bit 1) is 1, and 0xFFFF when that bit is 0. The wrap period is therefore (top+1)*ratio cycles.
- R5: A write to the reload register takes effect only while reload-mode is 1. Otherwise the write is ignored.
- R6: A capture-pin edge copies the count into the capture register (0x6 low, 0x7 high) and sets the flag for that pin (bit 1 for pin 1, bit 2 for pin 2). The polarity bits at address 0x1 select the edge (bit 4 for pin 1, bit 5 for pin 2; 1 selects rising, 0 selects falling). The copied value is the count held after the clock edge that follows the edge first sampling the new pin level.
- R7: An edge of the opposite polarity changes neither the capture register nor the flags.
- R8: With restart mode set (address 0x0, bit 2) and the block running, a selected edge on pin 2 captures the count and loads the top value into the counter in the same cycle. No overflow is flagged.
- R9: The PWM level is 1 when (count AND mask) > (compare AND mask), with compare at 0x8 low and 0x9 high. `pwm_out` equals the level XOR the polarity bit (address 0x1, bit 1) while the enable bit (address 0x1, bit 0) is 1, and is 0 otherwise.
- R10: The compare flag (flags bit 3) is set when an update occurs while (count AND mask) equals (compare AND mask).
- R11: `ovf_out` carries a one-cycle pulse in the cycle after each wrap, XORed with the polarity bit (address 0x1, bit 3), while the enable bit (address 0x1, bit 2) is 1. It is 0 while that enable is 0.
- R12: Flags stay set until cleared. A write to address 0x3 clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. `irq` is the OR of the flags ANDed with the enables at address 0x2, which use the same bit positions as the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 4 | Register address, used for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| cap1_pin | input | 1 | Capture input 1, asynchronous |
| cap2_pin | input | 1 | Capture input 2, asynchronous; can also trigger a restart |
| pwm_out | output | 1 | Masked-compare PWM output |
| ovf_out | output | 1 | Wrap pulse output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the counter's cycle-to-cycle law on every cycle: it is held at zero while stopped, it decrements by exactly one per update, it loads the top value at zero or on a restart, a detected edge lasts a single cycle, a write to the locked reload register has no effect, and a wrap always sets its flag. Other behaviour only shows up over a whole scenario, and the bench's sweeps cover it: the actual spacing of updates for each prescaler ratio, the latency of the synchroniser to the captured value, the ignored edge polarity, the event-to-event values captured under restart, and the PWM and overflow waveforms for each polarity and mask.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 4;
  localparam int NCAP   = 2;
  localparam int NFLAG  = 4;

  typedef logic [CNT_W-1:0] cnt_t;

  // flag / interrupt-enable bit positions
  localparam int FLG_OVF = 0;
  localparam int FLG_CP1 = 1;
  localparam int FLG_CP2 = 2;
  localparam int FLG_CMP = 3;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL0  = 4'h0;
  localparam logic [ADDR_W-1:0] A_CTRL1  = 4'h1;
  localparam logic [ADDR_W-1:0] A_IEN    = 4'h2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'h3;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 4'h4;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 4'h5;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 4'h6;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 4'h7;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 4'h8;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 4'h9;
  localparam logic [ADDR_W-1:0] A_MSK_LO = 4'hA;
  localparam logic [ADDR_W-1:0] A_MSK_HI = 4'hB;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 4'hC;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 4'hD;
endpackage

// File: rtl/rct_edge_sync.sv
module rct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic lvl_now, lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign lvl_now  = sh_q[STAGES-1];
  assign lvl_prev = sh_q[STAGES];
  assign edge_o   = rise_i ? (lvl_now & ~lvl_prev) : (~lvl_now & lvl_prev);

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> (!edge_o || !$stable(rise_i))); // R6
endmodule

// File: rtl/rct_prescaler.sv
module rct_prescaler #(
  parameter int SEL_W = 2,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PCW = ((1 << SEL_W) - 1) * STEP + 1;
  localparam logic [PCW-1:0] ONE = PCW'(1);

  logic [PCW-1:0] div_q;
  logic [PCW-1:0] limit;
  logic [7:0]     shamt;

  assign shamt  = 8'(sel_i) * 8'(STEP);
  assign limit  = (ONE << shamt) - ONE;
  assign tick_o = run_i && (div_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          div_q <= '0;
    else if (!run_i || clear_i || tick_o) div_q <= '0;
    else                                 div_q <= div_q + ONE;
  end
endmodule

// File: rtl/rct_counter.sv
module rct_counter
  import rct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic restart_i,
  input  cnt_t top_i,
  output cnt_t cnt_o,
  output logic wrap_o
);
  cnt_t cnt_q;

  assign wrap_o = run_i && tick_i && !restart_i && (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (restart_i) cnt_q <= top_i;
    else if (tick_i)    cnt_q <= (cnt_q == '0) ? top_i : cnt_q - 1'b1;
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> cnt_q == '0); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !restart_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_ZERO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !restart_i && cnt_q == '0) |=> cnt_q == $past(top_i)); // R4
  AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && restart_i) |=> cnt_q == $past(top_i)); // R8
endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer
  import rct_pkg::*;
#(
  parameter int PSC_SEL_W   = 2,
  parameter int PSC_STEP    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              cap1_pin,
  input  logic              cap2_pin,
  output logic              pwm_out,
  output logic              ovf_out,
  output logic              irq
);
  localparam int SEL_LSB = 3;

  // control state
  logic                 run_q, rmode_q, rstart_q;
  logic [PSC_SEL_W-1:0] psc_sel_q;
  logic                 pwm_en_q, pwm_pol_q, ovf_en_q, ovf_pol_q;
  logic [NCAP-1:0]      cap_rise_q;
  logic [NFLAG-1:0]     ien_q, flags_q, events;
  cnt_t                 reload_q, capt_q, cmp_q, mask_q;
  logic                 ovf_pulse_q;

  // datapath
  logic [NCAP-1:0] cap_pins, cap_edge;
  logic            tick, restart, wrap, cmp_hit, pwm_lvl;
  cnt_t            cnt, top;

  assign cap_pins = {cap2_pin, cap1_pin};

  for (genvar gi = 0; gi < NCAP; gi++) begin : g_cap
    rct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (cap_pins[gi]),
      .rise_i (cap_rise_q[gi]),
      .edge_o (cap_edge[gi])
    );
  end

  assign restart = run_q && rstart_q && cap_edge[NCAP-1];
  assign top     = rmode_q ? reload_q : '1;

  rct_prescaler #(.SEL_W(PSC_SEL_W), .STEP(PSC_STEP)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_q),
    .clear_i (restart),
    .sel_i   (psc_sel_q),
    .tick_o  (tick)
  );

  rct_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .tick_i    (tick),
    .restart_i (restart),
    .top_i     (top),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  assign cmp_hit = run_q && tick && ((cnt & mask_q) == (cmp_q & mask_q));
  assign pwm_lvl = (cnt & mask_q) > (cmp_q & mask_q);

  always_comb begin
    events          = '0;
    events[FLG_OVF] = wrap;
    events[FLG_CP1] = cap_edge[0];
    events[FLG_CP2] = cap_edge[1];
    events[FLG_CMP] = cmp_hit;
  end

  // software-written registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      rmode_q    <= 1'b0;
      rstart_q   <= 1'b0;
      psc_sel_q  <= '0;
      pwm_en_q   <= 1'b0;
      pwm_pol_q  <= 1'b0;
      ovf_en_q   <= 1'b0;
      ovf_pol_q  <= 1'b0;
      cap_rise_q <= '0;
      ien_q      <= '0;
      reload_q   <= '1;
      cmp_q      <= '0;
      mask_q     <= '1;
    end else if (wr_en) begin
      case (addr)
        A_CTRL0: begin
          run_q     <= wr_data[0];
          rmode_q   <= wr_data[1];
          rstart_q  <= wr_data[2];
          psc_sel_q <= wr_data[SEL_LSB +: PSC_SEL_W];
        end
        A_CTRL1: begin
          pwm_en_q   <= wr_data[0];
          pwm_pol_q  <= wr_data[1];
          ovf_en_q   <= wr_data[2];
          ovf_pol_q  <= wr_data[3];
          cap_rise_q <= wr_data[4 +: NCAP];
        end
        A_IEN:    ien_q <= wr_data[NFLAG-1:0];
        A_RLD_LO: if (rmode_q) reload_q[7:0]  <= wr_data;
        A_RLD_HI: if (rmode_q) reload_q[15:8] <= wr_data;
        A_CMP_LO: cmp_q[7:0]   <= wr_data;
        A_CMP_HI: cmp_q[15:8]  <= wr_data;
        A_MSK_LO: mask_q[7:0]  <= wr_data;
        A_MSK_HI: mask_q[15:8] <= wr_data;
        default: ;
      endcase
    end
  end

  // sticky flags: hardware set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flags_q <= '0;
    else if (wr_en && addr == A_FLAGS) flags_q <= (flags_q & wr_data[NFLAG-1:0]) | events;
    else                               flags_q <= flags_q | events;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q      <= '0;
      ovf_pulse_q <= 1'b0;
    end else begin
      if (|cap_edge) capt_q <= cnt;
      ovf_pulse_q <= wrap;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL0:  rd_data = 8'({psc_sel_q, rstart_q, rmode_q, run_q});
      A_CTRL1:  rd_data = 8'({cap_rise_q, ovf_pol_q, ovf_en_q, pwm_pol_q, pwm_en_q});
      A_IEN:    rd_data = 8'(ien_q);
      A_FLAGS:  rd_data = 8'(flags_q);
      A_RLD_LO: rd_data = reload_q[7:0];
      A_RLD_HI: rd_data = reload_q[15:8];
      A_CAP_LO: rd_data = capt_q[7:0];
      A_CAP_HI: rd_data = capt_q[15:8];
      A_CMP_LO: rd_data = cmp_q[7:0];
      A_CMP_HI: rd_data = cmp_q[15:8];
      A_MSK_LO: rd_data = mask_q[7:0];
      A_MSK_HI: rd_data = mask_q[15:8];
      A_CNT_LO: rd_data = cnt[7:0];
      A_CNT_HI: rd_data = cnt[15:8];
      default:  rd_data = 8'h00;
    endcase
  end

  assign pwm_out = pwm_en_q & (pwm_lvl ^ pwm_pol_q);
  assign ovf_out = ovf_en_q & (ovf_pulse_q ^ ovf_pol_q);
  assign irq     = |(flags_q & ien_q);

  AST_RELOAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_RLD_LO || addr == A_RLD_HI) && !rmode_q) |=> $stable(reload_q)); // R5
  AST_WRAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags_q[FLG_OVF]); // R4
  AST_CAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_edge[1] |=> (flags_q[FLG_CP2] && capt_q == $past(cnt))); // R6
endmodule

// File: tb/reload_capture_timer_bench.sv
module reload_capture_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cap1_pin = 1'b0;
  logic       cap2_pin = 1'b0;
  logic       pwm_out, ovf_out, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  localparam logic [3:0] CTRL0 = 4'h0, CTRL1 = 4'h1, IEN = 4'h2, FLAGS = 4'h3,
                         RLD = 4'h4, CAP = 4'h6, CMP = 4'h8, MSK = 4'hA, CNT = 4'hC;

  logic [15:0] masks [4] = '{16'hFFFF, 16'h000F, 16'h0006, 16'h0000};
  logic [15:0] cmps  [3] = '{16'h0000, 16'hFFF8, 16'h0005};

  always #5 clk = ~clk;

  reload_capture_timer u_reload_capture_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cap1_pin(cap1_pin), .cap2_pin(cap2_pin),
    .pwm_out(pwm_out), .ovf_out(ovf_out), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(4'(a + 4'd1), d[15:8]);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd8(a, lo);
    rd8(4'(a + 4'd1), hi);
    d = {hi, lo};
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    logic [15:0] v, c, c0;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd16(CNT, v);   check(v == 16'h0, "R1 count", int'(v), 0);
    rd8(FLAGS, b);  check(b == 8'h0, "R1 flags", int'(b), 0);
    check({pwm_out, ovf_out, irq} == 3'b000, "R1 outputs", int'({pwm_out, ovf_out, irq}), 0);
    rd16(RLD, v);   check(v == 16'hFFFF, "R1 reload", int'(v), 'hFFFF);
    rd16(MSK, v);   check(v == 16'hFFFF, "R1 mask", int'(v), 'hFFFF);

    // R5 reload write lock
    wr(RLD, 8'h12);
    rd16(RLD, v);   check(v == 16'hFFFF, "R5 locked write ignored", int'(v), 'hFFFF);
    wr(CTRL0, 8'h02);
    wr16(RLD, 16'h0012);
    rd16(RLD, v);   check(v == 16'h0012, "R5 write in reload mode", int'(v), 'h12);

    // R3 / R4 sweep over prescaler and top value
    for (int sel = 0; sel < 4; sel++) begin
      for (int mode = 0; mode < 3; mode++) begin
        int top, ratio, rm;
        top   = (mode == 0) ? 'hFFFF : ((mode == 1) ? 2 : 5);
        ratio = 1 << sel;
        rm    = (mode != 0) ? 1 : 0;
        wr(CTRL0, 8'(rm << 1));
        if (rm == 1) wr16(RLD, 16'(top));
        wr(FLAGS, 8'h00);
        wr(CTRL0, 8'((sel << 3) | (rm << 1) | 1));
        for (int j = 1; j <= 40; j++) begin
          int u, e;
          @(negedge clk);
          u = j / ratio;
          e = (u == 0) ? 0 : top - ((u - 1) % (top + 1));
          rd16(CNT, v);
          check(int'(v) == e, "R3 R4 count sequence", int'(v), e);
          rd8(FLAGS, b);
          check(b[0] == (u >= 1), "R4 overflow flag", int'(b[0]), int'(u >= 1));
        end
      end
    end

    // R2 stop holds count at zero, no events
    wr(CTRL0, 8'h00);
    wr(FLAGS, 8'h00);
    repeat (6) @(negedge clk);
    rd16(CNT, v);  check(v == 16'h0, "R2 stopped count", int'(v), 0);
    rd8(FLAGS, b); check(b == 8'h0, "R2 no events while stopped", int'(b), 0);

    // R6 / R7 capture on pin 1 rising, pin 2 falling
    wr(CTRL1, 8'h10);
    wr(CTRL0, 8'h01);
    repeat (5) @(negedge clk);
    wr(FLAGS, 8'h00);
    rd16(CNT, c);
    cap1_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd16(CAP, v);  check(v == 16'(c - 16'd2), "R6 pin1 rising capture", int'(v), int'(16'(c - 16'd2)));
    rd8(FLAGS, b); check(b[1] == 1'b1, "R6 pin1 flag", int'(b[1]), 1);
    c0 = v;
    wr(FLAGS, 8'h00);
    cap1_pin = 1'b0;
    repeat (4) @(negedge clk);
    rd16(CAP, v);  check(v == c0, "R7 pin1 falling ignored capture", int'(v), int'(c0));
    rd8(FLAGS, b); check(b[1] == 1'b0, "R7 pin1 falling ignored flag", int'(b[1]), 0);
    cap2_pin = 1'b1;
    repeat (4) @(negedge clk);
    rd16(CAP, v);  check(v == c0, "R7 pin2 rising ignored capture", int'(v), int'(c0));
    rd8(FLAGS, b); check(b[2] == 1'b0, "R7 pin2 rising ignored flag", int'(b[2]), 0);
    rd16(CNT, c);
    cap2_pin = 1'b0;
    repeat (3) @(negedge clk);
    rd16(CAP, v);  check(v == 16'(c - 16'd2), "R6 pin2 falling capture", int'(v), int'(16'(c - 16'd2)));
    rd8(FLAGS, b); check(b[2] == 1'b1, "R6 pin2 flag", int'(b[2]), 1);

    // R8 restart on pin 2, event-to-event capture
    wr(CTRL0, 8'h02);
    wr16(RLD, 16'd100);
    wr(CTRL1, 8'h20);
    wr(CTRL0, 8'h07);
    repeat (10) @(negedge clk);
    wr(FLAGS, 8'h00);
    rd16(CNT, c);
    cap2_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd16(CAP, v);  check(v == 16'(c - 16'd2), "R8 capture before restart", int'(v), int'(16'(c - 16'd2)));
    rd16(CNT, v);  check(v == 16'd100, "R8 count restarted", int'(v), 100);
    rd8(FLAGS, b); check(b[0] == 1'b0 && b[2] == 1'b1, "R8 no overflow on restart", int'(b), 4);
    cap2_pin = 1'b0;
    repeat (5) @(negedge clk);
    cap2_pin = 1'b1;
    repeat (3) @(negedge clk);
    rd16(CAP, v);  check(v == 16'd93, "R8 event interval capture", int'(v), 93);
    rd16(CNT, v);  check(v == 16'd100, "R8 second restart", int'(v), 100);
    cap2_pin = 1'b0;

    // R9 masked compare PWM sweep
    for (int mi = 0; mi < 4; mi++) begin
      for (int ci = 0; ci < 3; ci++) begin
        for (int pol = 0; pol < 2; pol++) begin
          wr(CTRL0, 8'h00);
          wr16(MSK, masks[mi]);
          wr16(CMP, cmps[ci]);
          wr(CTRL1, 8'(1 | (pol << 1)));
          wr(CTRL0, 8'h01);
          for (int k = 0; k < 12; k++) begin
            logic e;
            @(negedge clk);
            rd16(CNT, c);
            e = ((c & masks[mi]) > (cmps[ci] & masks[mi])) ^ pol[0];
            check(pwm_out == e, "R9 pwm level", int'(pwm_out), int'(e));
          end
        end
      end
    end
    wr(CTRL1, 8'h02);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pwm_out == 1'b0, "R9 pwm disabled", int'(pwm_out), 0);
    end

    // R10 compare flag
    wr(CTRL0, 8'h00);
    wr16(MSK, 16'h000F);
    wr16(CMP, 16'h0003);
    wr(IEN, 8'h08);
    wr(FLAGS, 8'h00);
    wr(CTRL0, 8'h01);
    repeat (20) @(negedge clk);
    rd8(FLAGS, b); check(b[3] == 1'b1, "R10 masked match flag", int'(b[3]), 1);
    check(irq == 1'b1, "R12 irq from compare", int'(irq), 1);
    wr(CTRL0, 8'h00);
    wr(FLAGS, 8'hF7);
    rd8(FLAGS, b); check(b[3] == 1'b0, "R12 write zero clears", int'(b[3]), 0);
    check(irq == 1'b0, "R12 irq drops", int'(irq), 0);
    wr16(MSK, 16'hFFFF);
    wr(CTRL0, 8'h01);
    repeat (20) @(negedge clk);
    rd8(FLAGS, b); check(b[3] == 1'b0, "R10 no full-mask match", int'(b[3]), 0);
    wr(CTRL0, 8'h00);
    wr(IEN, 8'h00);

    // R11 overflow output, top 2
    wr(CTRL0, 8'h02);
    wr16(RLD, 16'd2);
    for (int en = 0; en < 2; en++) begin
      for (int pol = 0; pol < 2; pol++) begin
        wr(CTRL0, 8'h02);
        wr(CTRL1, 8'((en << 2) | (pol << 3)));
        wr(FLAGS, 8'h00);
        wr(CTRL0, 8'h03);
        for (int j = 1; j <= 9; j++) begin
          logic e;
          @(negedge clk);
          e = (en == 1) ? ((((j - 1) % 3) == 0) ^ pol[0]) : 1'b0;
          check(ovf_out == e, "R11 overflow output", int'(ovf_out), int'(e));
        end
      end
    end

    // R12 sticky flags and interrupt gating
    wr(CTRL0, 8'h02);
    check(irq == 1'b0, "R12 irq masked", int'(irq), 0);
    wr(IEN, 8'h01);
    check(irq == 1'b1, "R12 irq enabled", int'(irq), 1);
    wr(FLAGS, 8'hFF);
    rd8(FLAGS, b); check(b == 8'h01, "R12 write one keeps", int'(b), 1);
    wr(FLAGS, 8'hFE);
    rd8(FLAGS, b); check(b == 8'h00, "R12 write zero clears overflow", int'(b), 0);
    check(irq == 1'b0, "R12 irq cleared", int'(irq), 0);

    summary();
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-all: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule